// File: doc/BRIEF.md
# Flash Sector Protection Register Unit

This block is the control and status register unit of a serial NOR flash controller. It sits between a 32-bit register bus and the flash command engine. It holds a 4-bit protect code and a top/bottom select bit. It turns writes to its operation register into bulk-erase, sector-erase and protect commands. It also watches every data write into the memory window.

Each erase and each window write is checked against the protected region, which is derived from the current protect code and the top/bottom select. A refused request never reaches the engine. Instead it sets a sticky flag in the interrupt status register, which software clears by writing 1 to the flag. An accepted request is passed on as a one-cycle pulse in the cycle after the bus write. The device size in sectors and the ID words are parameters. The sector size is 64 KiB.

Top module: `flash_prot_csr`

## Requirements
- R1: After reset, the status, interrupt status and interrupt mask registers read 0, `irq` is low, and no engine request is raised.
- R2: Reads at byte offset 0x04 return the SILICON_ID parameter and reads at 0x08 return the DEVICE_ID parameter. Offset 0x14 reads back the 2-bit interrupt mask in bits [1:0]. Offset 0x18 reads back the chip-select value in bits [CS_W-1:0], and `chip_sel` drives that same value.
- R3: A write to offset 0x0C with bits [1:0] = 3 loads a protect code from bits [11:8] and a top/bottom bit from bit 12. Status at 0x00 then shows code bits 2:0 in bits [4:2], code bit 3 in bit 6 and top/bottom in bit 5. All other status bits read 0. The protect state changes on no other write.
- R4: Code 0 protects nothing. Code N>0 protects 2^(N-1) sectors, limited to the device size. With top/bottom 0 the region ends at the last sector; with top/bottom 1 it starts at sector 0.
- R5: A write to 0x0C with bits [1:0] = 2 is a sector erase of the sector in bits [31:8]. If that sector exists and lies outside the region, `eng_sector_erase` pulses for one cycle in the next cycle and `eng_sector` carries the index. Otherwise no pulse is raised and interrupt status bit 0 is set.
- R6: A write to 0x0C with bits [1:0] = 1 is a bulk erase. It pulses `eng_bulk_erase` in the next cycle only when the protect code is 0. Otherwise it sets interrupt status bit 0.
- R7: A window write whose sector (address bits above the low 16) lies outside the region pulses `eng_write` in the next cycle with the same address and data. Inside the region, it sets interrupt status bit 1 and raises no pulse.
- R8: Writing 1 to a bit at offset 0x10 clears that interrupt status bit. A flag raised in the same cycle as a clear stays set.
- R9: `irq` is high exactly when some interrupt status bit and its mask bit are both 1.
- R10: A write to 0x0C with bits [1:0] = 0 changes nothing and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| win_wr | input | 1 | Memory window data write strobe |
| win_addr | input | MEM_AW | Window byte address |
| win_wdata | input | 32 | Window write data |
| eng_bulk_erase | output | 1 | Bulk erase request pulse |
| eng_sector_erase | output | 1 | Sector erase request pulse |
| eng_sector | output | IDX_W | Sector index for the erase pulse |
| eng_write | output | 1 | Accepted window write pulse |
| eng_write_addr | output | MEM_AW | Address of the accepted write |
| eng_write_data | output | 32 | Data of the accepted write |
| chip_sel | output | CS_W | Chip-select register value |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that register writes and window writes are single-cycle strobes with stable address and data while the strobe is high. They also assume that the two request sources may coincide only as a window write next to a register write, never two erases at once. The bench drives every strobe for exactly one cycle, between falling edges. The only concurrent stimulus it issues is an interrupt-clear write in the same cycle as a refused window write, which is the case the set-over-clear rule covers.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam logic [4:0] ADDR_STATUS = 5'h00;
    localparam logic [4:0] ADDR_SID    = 5'h04;
    localparam logic [4:0] ADDR_DID    = 5'h08;
    localparam logic [4:0] ADDR_MEMOP  = 5'h0C;
    localparam logic [4:0] ADDR_ISR    = 5'h10;
    localparam logic [4:0] ADDR_IMR    = 5'h14;
    localparam logic [4:0] ADDR_CS     = 5'h18;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_BULK = 2'd1,
        OP_SECT = 2'd2,
        OP_PROT = 2'd3
    } memop_e;

    localparam int FLAG_ERASE = 0;
    localparam int FLAG_WRITE = 1;

endpackage

// File: rtl/fsp_region.sv
// Turns protect code and top/bottom select into a half-open sector range [lo, hi).
module fsp_region #(
    parameter int SECTORS = 64,
    parameter int CNT_W   = $clog2(SECTORS + 1)
) (
    input  logic [3:0]       code,
    input  logic             bottom,
    output logic [CNT_W-1:0] lo,
    output logic [CNT_W-1:0] hi
);
    localparam logic [15:0] SECT16 = 16'(SECTORS);

    logic [15:0]      raw_len;
    logic [CNT_W-1:0] len;

    always_comb begin
        raw_len = (code == 4'd0) ? 16'd0 : (16'd1 << (code - 4'd1));
        len     = (raw_len > SECT16) ? CNT_W'(SECTORS) : raw_len[CNT_W-1:0];
        if (bottom) begin
            lo = '0;
            hi = len;
        end else begin
            lo = CNT_W'(SECTORS) - len;
            hi = CNT_W'(SECTORS);
        end
    end
endmodule

// File: rtl/fsp_guard.sv
// Range hit test for one sector index.
module fsp_guard #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] sector,
    input  logic [CNT_W-1:0] lo,
    input  logic [CNT_W-1:0] hi,
    output logic             hit
);
    always_comb hit = (sector >= lo) && (sector < hi);
endmodule

// File: rtl/flash_prot_csr.sv
module flash_prot_csr
    import fsp_pkg::*;
#(
    parameter int          SECTORS    = 64,
    parameter int          SECT_LOG2  = 16,
    parameter int          CS_W       = 3,
    parameter logic [31:0] SILICON_ID = 32'h0000_0017,
    parameter logic [31:0] DEVICE_ID  = 32'h0020_BA18,
    localparam int         IDX_W      = $clog2(SECTORS),
    localparam int         CNT_W      = $clog2(SECTORS + 1),
    localparam int         MEM_AW     = IDX_W + SECT_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [4:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              win_wr,
    input  logic [MEM_AW-1:0] win_addr,
    input  logic [31:0]       win_wdata,
    output logic              eng_bulk_erase,
    output logic              eng_sector_erase,
    output logic [IDX_W-1:0]  eng_sector,
    output logic              eng_write,
    output logic [MEM_AW-1:0] eng_write_addr,
    output logic [31:0]       eng_write_data,
    output logic [CS_W-1:0]   chip_sel,
    output logic              irq
);

    typedef struct packed {
        logic [3:0]        code;
        logic              bottom;
        logic [1:0]        isr;
        logic [1:0]        imr;
        logic [CS_W-1:0]   cs;
        logic              bulk;
        logic              sect;
        logic [IDX_W-1:0]  sidx;
        logic              wr;
        logic [MEM_AW-1:0] waddr;
        logic [31:0]       wdata;
    } state_t;

    state_t st_d, st_q;

    // protected range
    logic [CNT_W-1:0] reg_lo, reg_hi;

    fsp_region #(.SECTORS(SECTORS), .CNT_W(CNT_W)) u_region (
        .code   (st_q.code),
        .bottom (st_q.bottom),
        .lo     (reg_lo),
        .hi     (reg_hi)
    );

    // guard 0: erase target, guard 1: window write target
    logic [1:0][CNT_W-1:0] g_sector;
    logic [1:0]            g_hit;

    assign g_sector[0] = CNT_W'(csr_wdata[8 +: IDX_W]);
    assign g_sector[1] = CNT_W'(win_addr[MEM_AW-1 -: IDX_W]);

    for (genvar g = 0; g < 2; g++) begin : g_guard
        fsp_guard #(.CNT_W(CNT_W)) u_guard (
            .sector (g_sector[g]),
            .lo     (reg_lo),
            .hi     (reg_hi),
            .hit    (g_hit[g])
        );
    end

    // sector field above the device is out of range
    logic sect_oob;
    assign sect_oob = (csr_wdata[31:8] >= 24'(SECTORS));

    logic unused_wbits;
    assign unused_wbits = ^csr_wdata[7:2];

    memop_e op;
    assign op = memop_e'(csr_wdata[1:0]);

    logic [1:0] flag_set, flag_clr;

    always_comb begin
        st_d      = st_q;
        st_d.bulk = 1'b0;
        st_d.sect = 1'b0;
        st_d.wr   = 1'b0;
        flag_set  = 2'b00;
        flag_clr  = 2'b00;

        if (csr_wr) begin
            unique case (csr_addr)
                ADDR_MEMOP: begin
                    unique case (op)
                        OP_BULK: begin
                            if (st_q.code == 4'd0) st_d.bulk = 1'b1;
                            else flag_set[FLAG_ERASE] = 1'b1;
                        end
                        OP_SECT: begin
                            if (!sect_oob && !g_hit[0]) begin
                                st_d.sect = 1'b1;
                                st_d.sidx = csr_wdata[8 +: IDX_W];
                            end else begin
                                flag_set[FLAG_ERASE] = 1'b1;
                            end
                        end
                        OP_PROT: begin
                            st_d.code   = csr_wdata[11:8];
                            st_d.bottom = csr_wdata[12];
                        end
                        default: ;
                    endcase
                end
                ADDR_ISR: flag_clr   = csr_wdata[1:0];
                ADDR_IMR: st_d.imr   = csr_wdata[1:0];
                ADDR_CS:  st_d.cs    = csr_wdata[CS_W-1:0];
                default: ;
            endcase
        end

        if (win_wr) begin
            if (g_hit[1]) begin
                flag_set[FLAG_WRITE] = 1'b1;
            end else begin
                st_d.wr    = 1'b1;
                st_d.waddr = win_addr;
                st_d.wdata = win_wdata;
            end
        end

        // a new flag outranks a clear in the same cycle
        st_d.isr = (st_q.isr & ~flag_clr) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        csr_rdata = '0;
        unique case (csr_addr)
            ADDR_STATUS: csr_rdata = {25'd0, st_q.code[3], st_q.bottom, st_q.code[2:0], 2'b00};
            ADDR_SID:    csr_rdata = SILICON_ID;
            ADDR_DID:    csr_rdata = DEVICE_ID;
            ADDR_ISR:    csr_rdata = {30'd0, st_q.isr};
            ADDR_IMR:    csr_rdata = {30'd0, st_q.imr};
            ADDR_CS:     csr_rdata = {{(32-CS_W){1'b0}}, st_q.cs};
            default:     csr_rdata = '0;
        endcase
    end

    // names seen by the bound checker
    logic [3:0] prot_code;
    logic [1:0] isr_bits;
    logic [1:0] imr_bits;
    assign prot_code = st_q.code;
    assign isr_bits  = st_q.isr;
    assign imr_bits  = st_q.imr;

    assign eng_bulk_erase   = st_q.bulk;
    assign eng_sector_erase = st_q.sect;
    assign eng_sector       = st_q.sidx;
    assign eng_write        = st_q.wr;
    assign eng_write_addr   = st_q.waddr;
    assign eng_write_data   = st_q.wdata;
    assign chip_sel         = st_q.cs;
    assign irq              = |(st_q.isr & st_q.imr);

endmodule

// File: rtl/fsp_chk.sv
module fsp_chk
    import fsp_pkg::*;
#(
    parameter int MEM_AW = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic [4:0]        csr_addr,
    input logic [31:0]       csr_wdata,
    input logic              win_wr,
    input logic [MEM_AW-1:0] win_addr,
    input logic              eng_bulk_erase,
    input logic              eng_sector_erase,
    input logic              eng_write,
    input logic [MEM_AW-1:0] eng_write_addr,
    input logic [3:0]        prot_code,
    input logic [1:0]        isr_bits,
    input logic [1:0]        imr_bits,
    input logic              irq
);
    // R5
    erase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_bulk_erase, eng_sector_erase}));

    // R5
    sect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_sector_erase |-> $past(csr_wr && csr_addr == ADDR_MEMOP && csr_wdata[1:0] == 2'd2));

    // R6
    bulk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_bulk_erase |-> $past(csr_wr && csr_addr == ADDR_MEMOP && csr_wdata[1:0] == 2'd1 && prot_code == 4'd0));

    // R7
    write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_write |-> ($past(win_wr) && eng_write_addr == $past(win_addr)));

    // R7
    write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_wr) && !eng_write) |-> isr_bits[1]);

    // R3
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(csr_wr) |-> $stable(prot_code));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(isr_bits & imr_bits));

endmodule

bind flash_prot_csr fsp_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .csr_wr           (csr_wr),
    .csr_addr         (csr_addr),
    .csr_wdata        (csr_wdata),
    .win_wr           (win_wr),
    .win_addr         (win_addr),
    .eng_bulk_erase   (eng_bulk_erase),
    .eng_sector_erase (eng_sector_erase),
    .eng_write        (eng_write),
    .eng_write_addr   (eng_write_addr),
    .prot_code        (prot_code),
    .isr_bits         (isr_bits),
    .imr_bits         (imr_bits),
    .irq              (irq)
);

// File: tb/sim_flash_prot_csr.sv
module sim_flash_prot_csr;

    localparam int          SECTORS = 64;
    localparam int          AW      = 22;
    localparam logic [31:0] SID     = 32'h0000_0017;
    localparam logic [31:0] DID     = 32'h0020_BA18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [4:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        win_wr = 1'b0;
    logic [AW-1:0] win_addr = '0;
    logic [31:0] win_wdata = '0;
    logic        eng_bulk_erase, eng_sector_erase, eng_write, irq;
    logic [5:0]  eng_sector;
    logic [AW-1:0] eng_write_addr;
    logic [31:0] eng_write_data;
    logic [2:0]  chip_sel;

    always #10 clk = ~clk;

    flash_prot_csr #(.SECTORS(SECTORS), .SILICON_ID(SID), .DEVICE_ID(DID)) u0 (
        .clk(clk), .rst_n(rst_n),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .win_wr(win_wr), .win_addr(win_addr), .win_wdata(win_wdata),
        .eng_bulk_erase(eng_bulk_erase), .eng_sector_erase(eng_sector_erase),
        .eng_sector(eng_sector), .eng_write(eng_write),
        .eng_write_addr(eng_write_addr), .eng_write_data(eng_write_data),
        .chip_sel(chip_sel), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard item: kind 1 bulk, 2 sector, 3 window write
    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [31:0] d;
        string       req;
    } item_t;
    item_t sb[$];

    int exp_code = 0;
    int exp_tb   = 0;
    logic [1:0] exp_isr = 2'b00;

    function automatic bit prot_hit(int code, int tb, int s);
        int len;
        if (code == 0) return 1'b0;
        len = 1 << (code - 1);
        if (len > SECTORS) len = SECTORS;
        if (tb != 0) return (s < len);
        return (s >= SECTORS - len);
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (eng_bulk_erase || eng_sector_erase || eng_write)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected request",
                      {29'd0, eng_write, eng_sector_erase, eng_bulk_erase}, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.kind == 1)
                    check(eng_bulk_erase && !eng_sector_erase && !eng_write, it.req, "bulk pulse",
                          {29'd0, eng_write, eng_sector_erase, eng_bulk_erase}, 32'd1);
                else if (it.kind == 2)
                    check(eng_sector_erase && !eng_bulk_erase && 32'(eng_sector) == it.a, it.req,
                          "sector pulse", 32'(eng_sector), it.a);
                else begin
                    check(eng_write && 32'(eng_write_addr) == it.a, it.req, "write addr",
                          32'(eng_write_addr), it.a);
                    check(eng_write_data == it.d, it.req, "write data", eng_write_data, it.d);
                end
            end
        end
    end

    task automatic wr_reg(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        csr_addr = a;
        #1;
        check(csr_rdata == exp, req, $sformatf("read @%h", a), csr_rdata, exp);
    endtask

    task automatic protect(int code, int tb);
        exp_code = code; exp_tb = tb;
        wr_reg(5'h0C, 32'((tb << 12) | (code << 8) | 3));
    endtask

    task automatic sect_erase(int s, string req);
        if (s < SECTORS && !prot_hit(exp_code, exp_tb, s)) begin
            item_t it;
            it.kind = 2; it.a = 32'(s); it.d = '0; it.req = req;
            sb.push_back(it);
        end else exp_isr[0] = 1'b1;
        wr_reg(5'h0C, 32'((s << 8) | 2));
    endtask

    task automatic bulk(string req);
        if (exp_code == 0) begin
            item_t it;
            it.kind = 1; it.a = '0; it.d = '0; it.req = req;
            sb.push_back(it);
        end else exp_isr[0] = 1'b1;
        wr_reg(5'h0C, 32'd1);
    endtask

    task automatic win_write(logic [AW-1:0] a, logic [31:0] d, string req);
        if (prot_hit(exp_code, exp_tb, int'(a >> 16))) exp_isr[1] = 1'b1;
        else begin
            item_t it;
            it.kind = 3; it.a = 32'(a); it.d = d; it.req = req;
            sb.push_back(it);
        end
        @(negedge clk);
        win_wr = 1'b1; win_addr = a; win_wdata = d;
        @(negedge clk);
        win_wr = 1'b0;
    endtask

    task automatic clr_isr(logic [1:0] v);
        exp_isr = exp_isr & ~v;
        wr_reg(5'h10, {30'd0, v});
    endtask

    function automatic logic [31:0] status_of(int code, int tb);
        return 32'(((code & 7) << 2) | (((code >> 3) & 1) << 6) | (tb << 5));
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        rd_chk(5'h00, 32'd0, "R1");
        rd_chk(5'h10, 32'd0, "R1");
        rd_chk(5'h14, 32'd0, "R1");
        check(irq == 1'b0, "R1", "irq after reset", {31'd0, irq}, 32'd0);
        // R2
        rd_chk(5'h04, SID, "R2");
        rd_chk(5'h08, DID, "R2");
        wr_reg(5'h18, 32'd5);
        rd_chk(5'h18, 32'd5, "R2");
        check(chip_sel == 3'd5, "R2", "chip_sel pin", 32'(chip_sel), 32'd5);
        wr_reg(5'h14, 32'd3);
        rd_chk(5'h14, 32'd3, "R2");
        wr_reg(5'h14, 32'd0);
        // R10
        wr_reg(5'h0C, 32'h0000_1F00);
        repeat (2) @(negedge clk);
        rd_chk(5'h00, 32'd0, "R10");
        rd_chk(5'h10, 32'd0, "R10");
        // R5, R6 with no protection
        sect_erase(0, "R5");
        sect_erase(63, "R5");
        bulk("R6");
        sect_erase(70, "R5");
        rd_chk(5'h10, {30'd0, exp_isr}, "R5");
        clr_isr(2'b01);
        rd_chk(5'h10, {30'd0, exp_isr}, "R8");
        // R3, R4: code 3, top -> sectors 60..63
        protect(3, 0);
        rd_chk(5'h00, status_of(3, 0), "R3");
        sect_erase(59, "R4");
        sect_erase(60, "R4");
        rd_chk(5'h10, {30'd0, exp_isr}, "R4");
        clr_isr(2'b01);
        bulk("R6");
        rd_chk(5'h10, {30'd0, exp_isr}, "R6");
        clr_isr(2'b01);
        // R7
        win_write(22'h3D_0000, 32'hDEAD_BEEF, "R7");
        win_write(22'h0A_1234, 32'h1234_5678, "R7");
        rd_chk(5'h10, {30'd0, exp_isr}, "R7");
        // R9
        check(irq == 1'b0, "R9", "irq masked", {31'd0, irq}, 32'd0);
        wr_reg(5'h14, 32'd2);
        @(negedge clk);
        check(irq == 1'b1, "R9", "irq enabled", {31'd0, irq}, 32'd1);
        clr_isr(2'b10);
        @(negedge clk);
        check(irq == 1'b0, "R9", "irq after clear", {31'd0, irq}, 32'd0);
        // R3, R4: code 9 bottom -> whole device
        protect(9, 1);
        rd_chk(5'h00, status_of(9, 1), "R3");
        sect_erase(63, "R4");
        rd_chk(5'h10, {30'd0, exp_isr}, "R4");
        clr_isr(2'b01);
        // R4: code 2 bottom -> sectors 0..1
        protect(2, 1);
        sect_erase(1, "R4");
        sect_erase(2, "R4");
        win_write(22'h01_0040, 32'hA5A5_0001, "R7");
        win_write(22'h02_0000, 32'hA5A5_0002, "R7");
        rd_chk(5'h10, {30'd0, exp_isr}, "R4");
        clr_isr(2'b11);
        // R4: code 15 top -> whole device
        protect(15, 0);
        rd_chk(5'h00, status_of(15, 0), "R3");
        sect_erase(0, "R4");
        win_write(22'h00_0010, 32'h0, "R7");
        rd_chk(5'h10, {30'd0, exp_isr}, "R4");
        clr_isr(2'b11);
        // R8: set outranks clear in the same cycle; code 1 top -> sector 63
        protect(1, 0);
        win_write(22'h3F_0000, 32'h1, "R8");
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = 5'h10; csr_wdata = 32'd2;
        win_wr = 1'b1; win_addr = 22'h3F_0004; win_wdata = 32'h2;
        @(negedge clk);
        csr_wr = 1'b0; win_wr = 1'b0;
        rd_chk(5'h10, 32'd2, "R8");
        clr_isr(2'b10);
        rd_chk(5'h10, 32'd0, "R8");
        // R3: protect with zero clears protection
        protect(0, 0);
        rd_chk(5'h00, 32'd0, "R3");
        bulk("R6");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R5", "pending scoreboard items", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule